// File: doc/BRIEF.md
# Parameter Byte Return Handshake

This block sits on the adapter side of a byte-wide data-in register. An internal command engine hands over the response bytes of an adapter command through a valid/ready pair. The block passes them to a host one byte at a time. A single data-full flag paces the exchange. Loading a byte sets the flag. A host read of the data register clears it. The engine may not place the next byte until that read has happened.

A transfer starts with a start strobe that carries the number of response bytes. The block raises a one-cycle completion request toward a separate interrupt-flag block in three cases:

- after the host has read the last byte,
- at once for a zero-length response,
- at once when the engine reports an invalid command. The transfer then ends early and a sticky error flag is set. The error flag stays set until an interrupt-reset command or a reset clears it.

Top module: `param_return_port`

## Requirements
- R1: After reset, status, rd_data, eng_ready and done_req are all zero.
- R2: While a transfer is active, bytes are still owed and the data-full flag (status bit 2) is clear, eng_ready is high. A byte accepted with eng_valid appears on rd_data in the next cycle, and status bit 2 is set in that same cycle.
- R3: When host_rd is high while status bit 2 is set, status bit 2 is clear in the next cycle.
- R4: eng_ready is low whenever status bit 2 is set. The engine can deliver exactly cmd_len bytes per transfer, and eng_ready stays low once all of them have been taken.
- R5: done_req pulses for one cycle in the cycle after the host reads the final byte. It does not pulse on any earlier read.
- R6: A cmd_start with cmd_len equal to zero raises done_req in the next cycle.
- R7: cmd_invalid ends any transfer. In the next cycle eng_ready is low, done_req is high and the invalid flag (status bit 0) is set.
- R8: Status bit 0 stays set until irq_rst clears it in the following cycle. If cmd_invalid and irq_rst are high in the same cycle, the bit is set.
- R9: When status bit 2 is clear, host_rd leaves rd_data, status and done_req unchanged.
- R10: cmd_start is ignored while a transfer is active. The byte count of that transfer is not changed.
- R11: If cmd_invalid arrives in the same cycle as the read of the final byte, done_req is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Begin returning a response of cmd_len bytes |
| cmd_len | input | LEN_W | Number of response bytes |
| cmd_invalid | input | 1 | Engine reports an invalid command and aborts |
| eng_valid | input | 1 | Engine offers a byte |
| eng_data | input | DATA_W | Byte offered by the engine |
| eng_ready | output | 1 | Block accepts the offered byte |
| host_rd | input | 1 | Host read strobe of the data register |
| rd_data | output | DATA_W | Data-in register contents |
| irq_rst | input | 1 | Interrupt-reset command; clears the invalid flag |
| status | output | 8 | Bit 2 data-full, bit 0 invalid command, others zero |
| done_req | output | 1 | One-cycle command-complete request |

## Verification
Two completion sources can meet in one cycle: the host read of the final byte and an invalid-command abort. The bench builds a one-byte transfer, loads the byte, and then drives host_rd and cmd_invalid together. It checks that done_req is high in the next cycle and low in the cycle after, and that the invalid flag is set. The random phase also lets aborts, interrupt resets and final reads coincide. A bench model built from the requirements judges each of those cycles.

// File: rtl/pr_pkg.sv
// Shared constants for the parameter byte return handshake.
// Assumes an 8-bit status register whose bit positions are decoded by the host.
package pr_pkg;
    localparam int STAT_W   = 8;
    localparam int FULL_BIT = 2;
    localparam int INV_BIT  = 0;
endpackage

// File: rtl/pr_pace.sv
// Transfer pacing: tracks whether a response is in progress and how many
// bytes the engine still owes. Reports the normal completion event.
// Assumes read_clear only pulses when the data register held a byte.
module pr_pace #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [LEN_W-1:0] start_len,
    input  logic             load_fire,
    input  logic             read_clear,
    input  logic             abort,
    output logic             active_o,
    output logic             owed_o,
    output logic             finish_o
);
    logic             active_q;
    logic [LEN_W-1:0] left_q;
    logic             start_ok;
    logic             last_taken;

    // Decode when a start is honoured and when the final byte has been read.
    always_comb begin
        start_ok   = start_req && !active_q && !abort;
        last_taken = active_q && (left_q == '0) && read_clear;
        finish_o   = (start_ok && (start_len == '0)) || last_taken;
    end

    // Hold the active state and the count of bytes still owed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            left_q   <= '0;
        end else if (abort) begin
            active_q <= 1'b0;
            left_q   <= '0;
        end else begin
            if (load_fire)
                left_q <= left_q - 1'b1;
            if (last_taken)
                active_q <= 1'b0;
            if (start_ok && (start_len != '0)) begin
                active_q <= 1'b1;
                left_q   <= start_len;
            end
        end
    end

    assign active_o = active_q;
    assign owed_o   = (left_q != '0);
endmodule

// File: rtl/pr_hold.sv
// Data-in holding register with its data-full flag.
// Assumes the loader never loads while the flag is set.
module pr_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_fire,
    input  logic [DATA_W-1:0] load_data,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              read_clear_o
);
    logic [DATA_W-1:0] data_q;
    logic              full_q;

    // A read only counts when a byte was waiting.
    assign read_clear_o = rd_strobe && full_q;

    // Capture a loaded byte and keep the flag until the host reads it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else if (load_fire) begin
            data_q <= load_data;
            full_q <= 1'b1;
        end else if (read_clear_o) begin
            full_q <= 1'b0;
        end
    end

    assign data_o = data_q;
    assign full_o = full_q;
endmodule

// File: rtl/pr_flags.sv
// Completion request and sticky invalid-command flag.
// Assumes finish and abort may coincide; they merge into one pulse.
module pr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic finish,
    input  logic abort,
    input  logic irq_clear,
    output logic done_o,
    output logic inv_o
);
    logic done_q;
    logic inv_q;

    // Register the merged completion event and the set-dominant error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            inv_q  <= 1'b0;
        end else begin
            done_q <= finish || abort;
            if (abort)
                inv_q <= 1'b1;
            else if (irq_clear)
                inv_q <= 1'b0;
        end
    end

    assign done_o = done_q;
    assign inv_o  = inv_q;
endmodule

// File: rtl/param_return_port.sv
// Top of the parameter byte return handshake: joins pacing, the holding
// register and the flags, and assembles the status byte.
// Assumes the host strobes host_rd for one cycle per register read.
module param_return_port
    import pr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_invalid,
    input  logic              eng_valid,
    input  logic [DATA_W-1:0] eng_data,
    output logic              eng_ready,
    input  logic              host_rd,
    output logic [DATA_W-1:0] rd_data,
    input  logic              irq_rst,
    output logic [STAT_W-1:0] status,
    output logic              done_req
);
    logic active;
    logic owed;
    logic finish;
    logic full;
    logic read_clear;
    logic load_fire;
    logic inv;

    // Accept a byte only while a transfer owes one and the register is empty.
    always_comb begin
        eng_ready = active && owed && !full;
        load_fire = eng_valid && eng_ready;
    end

    pr_pace #(.LEN_W(LEN_W)) u_pace (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (cmd_start),
        .start_len  (cmd_len),
        .load_fire  (load_fire),
        .read_clear (read_clear),
        .abort      (cmd_invalid),
        .active_o   (active),
        .owed_o     (owed),
        .finish_o   (finish)
    );

    pr_hold #(.DATA_W(DATA_W)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_fire    (load_fire),
        .load_data    (eng_data),
        .rd_strobe    (host_rd),
        .data_o       (rd_data),
        .full_o       (full),
        .read_clear_o (read_clear)
    );

    pr_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .finish    (finish),
        .abort     (cmd_invalid),
        .irq_clear (irq_rst),
        .done_o    (done_req),
        .inv_o     (inv)
    );

    // Place the flags at their decoded bit positions; other bits read zero.
    always_comb begin
        status           = '0;
        status[FULL_BIT] = full;
        status[INV_BIT]  = inv;
    end
endmodule

// File: rtl/pr_chk.sv
// Protocol checker for param_return_port, attached with bind.
// Assumes it observes the top ports plus the internal active state.
module pr_chk
    import pr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eng_valid,
    input logic              eng_ready,
    input logic [DATA_W-1:0] eng_data,
    input logic              host_rd,
    input logic [DATA_W-1:0] rd_data,
    input logic [STAT_W-1:0] status,
    input logic              done_req,
    input logic              cmd_invalid,
    input logic              irq_rst,
    input logic              active
);
    // R4
    ready_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_ready |-> (!status[FULL_BIT] && active));

    // R2
    load_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_valid && eng_ready) |=> (status[FULL_BIT] && rd_data == $past(eng_data)));

    // R3
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && status[FULL_BIT]) |=> !status[FULL_BIT]);

    // R7
    invalid_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_invalid |=> (done_req && status[INV_BIT] && !eng_ready && !active));

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rst && !cmd_invalid) |=> !status[INV_BIT]);

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_valid && eng_ready) |=> $stable(rd_data));
endmodule

bind param_return_port pr_chk #(.DATA_W(DATA_W)) u_pr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eng_valid   (eng_valid),
    .eng_ready   (eng_ready),
    .eng_data    (eng_data),
    .host_rd     (host_rd),
    .rd_data     (rd_data),
    .status      (status),
    .done_req    (done_req),
    .cmd_invalid (cmd_invalid),
    .irq_rst     (irq_rst),
    .active      (active)
);

// File: tb/param_return_port_bench.sv
module param_return_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0;
    logic [7:0] cmd_len = '0;
    logic       cmd_invalid = 1'b0;
    logic       eng_valid = 1'b0;
    logic [7:0] eng_data = '0;
    logic       eng_ready;
    logic       host_rd = 1'b0;
    logic [7:0] rd_data;
    logic       irq_rst = 1'b0;
    logic [7:0] status;
    logic       done_req;

    int checks = 0;
    int errors = 0;

    // model state
    bit       m_active = 0;
    int       m_left = 0;
    bit       m_full = 0;
    bit [7:0] m_data = 0;
    bit       m_inv = 0;
    bit       m_done = 0;

    always #10 clk = ~clk;

    param_return_port u_param_return_port (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_len(cmd_len),
        .cmd_invalid(cmd_invalid), .eng_valid(eng_valid), .eng_data(eng_data),
        .eng_ready(eng_ready), .host_rd(host_rd), .rd_data(rd_data),
        .irq_rst(irq_rst), .status(status), .done_req(done_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_ready();
        return m_active && (m_left != 0) && !m_full;
    endfunction

    function automatic bit [7:0] exp_status();
        return {5'b0, m_full, 1'b0, m_inv};
    endfunction

    // Advance the model by one edge from the requirements.
    function automatic void model_edge();
        bit fire;
        bit rdc;
        bit fin;
        bit start_ok;
        fire     = eng_valid && exp_ready();
        rdc      = host_rd && m_full;
        start_ok = cmd_start && !m_active && !cmd_invalid;
        fin      = (start_ok && cmd_len == 0) || (m_active && m_left == 0 && rdc);
        m_done   = fin || cmd_invalid;
        if (cmd_invalid) m_inv = 1;
        else if (irq_rst) m_inv = 0;
        if (fire) begin
            m_full = 1;
            m_data = eng_data;
        end else if (rdc) begin
            m_full = 0;
        end
        if (cmd_invalid) begin
            m_active = 0;
            m_left   = 0;
        end else begin
            if (fire) m_left = m_left - 1;
            if (m_active && m_left == 0 && rdc) m_active = 0;
            if (start_ok && cmd_len != 0) begin
                m_active = 1;
                m_left   = int'(cmd_len);
            end
        end
    endfunction

    // One cycle: check ready, take the edge, check registered outputs.
    task automatic step();
        #2;
        chk(eng_ready == exp_ready(), "R4 eng_ready", int'(eng_ready), int'(exp_ready()));
        @(posedge clk);
        model_edge();
        #1;
        chk(rd_data == m_data, "R2 rd_data", int'(rd_data), int'(m_data));
        chk(status == exp_status(), "R3 R8 status", int'(status), int'(exp_status()));
        chk(done_req == m_done, "R5 done_req", int'(done_req), int'(m_done));
    endtask

    task automatic idle_in();
        cmd_start = 0; cmd_invalid = 0; eng_valid = 0; host_rd = 0; irq_rst = 0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4021));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        chk(status == 0 && rd_data == 0 && !done_req && !eng_ready, "R1 reset",
            int'({status, rd_data}), 0);

        // R6 zero-length response
        cmd_start = 1; cmd_len = 0;
        step();
        chk(done_req == 1, "R6 zero length", int'(done_req), 1);
        idle_in();
        step();

        // R5 two-byte transfer, done only after final read
        cmd_start = 1; cmd_len = 2;
        step();
        idle_in();
        // R10 start while active is ignored
        cmd_start = 1; cmd_len = 7;
        step();
        idle_in();
        eng_valid = 1; eng_data = 8'hA5;
        step();
        chk(rd_data == 8'hA5 && status[2], "R2 load", int'(rd_data), 8'hA5);
        eng_valid = 1; eng_data = 8'h11;
        step();
        chk(rd_data == 8'hA5, "R4 no overwrite", int'(rd_data), 8'hA5);
        eng_valid = 0; host_rd = 1;
        step();
        chk(!done_req && !status[2], "R5 early read no done", int'(done_req), 0);
        host_rd = 0;
        // R9 read while empty
        host_rd = 1;
        step();
        chk(rd_data == 8'hA5 && !done_req && status == 0, "R9 empty read", int'(rd_data), 8'hA5);
        host_rd = 0; eng_valid = 1; eng_data = 8'h3C;
        step();
        eng_valid = 1; eng_data = 8'h77;
        step();
        eng_valid = 0; host_rd = 1;
        step();
        chk(done_req == 1, "R5 final read done", int'(done_req), 1);
        host_rd = 0;
        // R10 only two bytes were owed despite the second start
        eng_valid = 1;
        step();
        chk(!eng_ready && !status[2], "R10 count kept", int'(status), 0);
        idle_in();

        // R7 invalid mid-transfer
        cmd_start = 1; cmd_len = 4;
        step();
        idle_in(); eng_valid = 1; eng_data = 8'h5A;
        step();
        eng_valid = 0; host_rd = 1;
        step();
        host_rd = 0; cmd_invalid = 1;
        step();
        chk(done_req && status[0] && !eng_ready, "R7 abort", int'(status), 1);
        idle_in();
        step();
        chk(status[0] == 1, "R8 sticky", int'(status), 1);
        // R8 set wins over clear
        cmd_invalid = 1; irq_rst = 1;
        step();
        chk(status[0] == 1, "R8 set wins", int'(status), 1);
        cmd_invalid = 0;
        step();
        chk(status[0] == 0, "R8 clear", int'(status), 0);
        idle_in();

        // R11 final read and invalid in one cycle
        cmd_start = 1; cmd_len = 1;
        step();
        idle_in(); eng_valid = 1; eng_data = 8'hC3;
        step();
        eng_valid = 0; host_rd = 1; cmd_invalid = 1;
        step();
        chk(done_req == 1, "R11 one pulse", int'(done_req), 1);
        idle_in();
        step();
        chk(done_req == 0, "R11 not repeated", int'(done_req), 0);
        irq_rst = 1;
        step();
        idle_in();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            cmd_start   = ($urandom_range(0, 9) == 0);
            cmd_len     = 8'($urandom_range(0, 5));
            cmd_invalid = ($urandom_range(0, 59) == 0);
            irq_rst     = ($urandom_range(0, 19) == 0);
            eng_valid   = ($urandom_range(0, 9) < 7);
            eng_data    = 8'($urandom);
            host_rd     = ($urandom_range(0, 9) < 4);
            step();
        end
        idle_in();
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule